// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Shadowed Period

This block makes two pulse-width-modulated outputs from one up-down time base. A counter climbs from zero to the active period and then falls back to zero, so a full cycle takes twice the period in clocks. Four events come from the counter: it reaches zero, it reaches the period, it meets the channel's compare value while climbing, or it meets that value while falling. For each event, each output has a two-bit action field that chooses no change, drive low, drive high or toggle.

The period can be written straight into the active copy, or into a shadow copy that moves to the active copy on a chosen counter event. Raising the load-mode select from direct to shadow copies the shadow value into the active period at once. When that shadow was never written, this loads zero. The counter stays still until the global time-base enable is raised. It then starts from zero. If the active period is zero at that moment, the zero and period events fire together, and the fixed event priority decides the outputs.

Top module: `updown_pwm_core`

## Requirements
- R1: After a synchronous reset, both outputs, the counter, the active period and the shadow period are 0, and the counting direction is up.
- R2: While `tb_en` is low the counter and both outputs hold. After enable, counting begins from 0, and the first edge with `tb_en` high evaluates the count 0.
- R3: With active period P > 0, the counter steps 0,1,...,P,P-1,...,1,0 and repeats every 2*P clocks. It turns down at the count P and turns up at the count 0.
- R4: Register writes use `wr_addr` 0 for the period, 1 for the compare value of A, 2 for the compare value of B, 3 for the action byte of A and 4 for the action byte of B. An action byte holds the zero-event action in bits [1:0], the period-event action in [3:2], the compare-up action in [5:4] and the compare-down action in [7:6].
- R5: Action codes are 0 no change, 1 drive low, 2 drive high, 3 toggle. The output register updates on the same edge at which the event's count is present.
- R6: With `load_mode` = 0, a period write goes into the active period on the next edge.
- R7: With `load_mode` = 1, a period write goes only into the shadow. The shadow moves into the active period on an edge with `tb_en` high where the count is 0 (`load_sel` = 0) or equals the active period (`load_sel` = 1).
- R8: A rise of `load_mode` from 0 to 1 copies the shadow period into the active period on the next edge.
- R9: When several events coincide, the action that takes effect comes from the highest-ranked event whose action is not "no change". The ranking is period, then zero, then compare.
- R10: A compare match counts as compare-up when the count is 0 or the counter is climbing. It counts as compare-down when the count is at or above the period, or the counter is falling.
- R11: With active period 0 the counter stays at 0, and the zero and period events both fire on every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Global time-base enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R4) |
| wr_data | input | 16 | Write data |
| load_mode | input | 1 | 0 direct period load, 1 shadowed period load |
| load_sel | input | 1 | Shadow load event: 0 count zero, 1 count equals period |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
The zero event and the period event are the two functions that can fall in the same cycle. The test provokes this by writing the period 300 in shadow mode before enabling the counter, so the active period is still zero at start. A is set high by the zero event. B is driven low by the zero event and high by the period event. The scoreboard therefore expects both outputs high after the first edge, then the normal 600-clock waveform shifted by one clock. A mode switch that loads an empty shadow keeps both events firing on every cycle. Compare events that coincide with the peak or the bottom are judged against the period and zero actions that outrank them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  typedef struct packed {
    act_e cdn;
    act_e cup;
    act_e prd;
    act_e zro;
  } act_cfg_t;

  localparam int unsigned ADDR_PRD   = 0;
  localparam int unsigned ADDR_CMP_A = 1;
  localparam int unsigned ADDR_CMP_B = 2;
  localparam int unsigned ADDR_ACT_A = 3;
  localparam int unsigned ADDR_ACT_B = 4;
endpackage

// File: rtl/pwm_period_reg.sv
module pwm_period_reg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_prd,
  input  logic [CW-1:0] wr_data,
  input  logic          load_mode,
  input  logic          load_evt,
  output logic [CW-1:0] prd_act
);
  logic [CW-1:0] prd_shd;
  logic          mode_q;
  logic          mode_rise;

  assign mode_rise = load_mode & ~mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prd_act <= '0;
      prd_shd <= '0;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= load_mode;
      if (load_mode && wr_prd) prd_shd <= wr_data;
      if (mode_rise)                 prd_act <= prd_shd;
      else if (!load_mode && wr_prd) prd_act <= wr_data;
      else if (load_mode && load_evt) prd_act <= prd_shd;
    end
  end

  // R8: a direct-to-shadow switch moves the shadow into the active copy
  p_mode_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (load_mode && !mode_q) |=> prd_act == $past(prd_shd));
  // R6: direct write lands in the active period
  p_direct_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && wr_prd) |=> prd_act == $past(wr_data));
  // R7: in shadow mode, without a load event, the active period holds
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (load_mode && mode_q && !load_evt) |=> $stable(prd_act));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic          up_eff,
  output logic          at_zero,
  output logic          at_prd
);
  logic dir_up;

  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd);

  always_comb begin
    if (at_zero)         up_eff = 1'b1;
    else if (cnt >= prd) up_eff = 1'b0;
    else                 up_eff = dir_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (en) begin
      dir_up <= up_eff;
      if (prd == '0)  cnt <= '0;
      else if (up_eff) cnt <= cnt + 1'b1;
      else            cnt <= cnt - 1'b1;
    end
  end

  // R2: disabled time base holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt) && $stable(dir_up));
  // R11: zero period pins the counter at zero
  p_zero_prd_r11: assert property (@(posedge clk) disable iff (rst)
    (en && prd == '0) |=> cnt == '0);
  // R3: counter moves by exactly one step per enabled clock when period is nonzero
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (en && prd != '0) |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwm_action_out.sv
module pwm_action_out
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ev_zro,
  input  logic     ev_prd,
  input  logic     ev_cup,
  input  logic     ev_cdn,
  input  act_cfg_t cfg,
  output logic     pwm_o
);
  act_e sel;

  always_comb begin
    sel = ACT_NONE;
    if (ev_cdn && cfg.cdn != ACT_NONE) sel = cfg.cdn;
    if (ev_cup && cfg.cup != ACT_NONE) sel = cfg.cup;
    if (ev_zro && cfg.zro != ACT_NONE) sel = cfg.zro;
    if (ev_prd && cfg.prd != ACT_NONE) sel = cfg.prd;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else begin
      case (sel)
        ACT_LOW:  pwm_o <= 1'b0;
        ACT_HIGH: pwm_o <= 1'b1;
        ACT_TGL:  pwm_o <= ~pwm_o;
        default:  pwm_o <= pwm_o;
      endcase
    end
  end

  // R9: period action wins over every other event
  p_prd_high_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_prd && cfg.prd == ACT_HIGH) |=> pwm_o);
  p_prd_low_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_prd && cfg.prd == ACT_LOW) |=> !pwm_o);
  // R5: no event, no change
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(ev_zro || ev_prd || ev_cup || ev_cdn) |=> $stable(pwm_o));
endmodule

// File: rtl/updown_pwm_core.sv
module updown_pwm_core
  import pwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tb_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          load_mode,
  input  logic          load_sel,
  output logic          out_a,
  output logic          out_b
);
  localparam int NCH = 2;
  localparam int ABITS = $bits(act_cfg_t);

  logic [CW-1:0] prd_act, cnt;
  logic          up_eff, at_zero, at_prd;
  logic          wr_prd, load_evt;
  logic [CW-1:0] cmp_r [NCH];
  act_cfg_t      act_r [NCH];
  logic [NCH-1:0] pwm;

  assign wr_prd   = wr_en && (wr_addr == AW'(ADDR_PRD));
  assign load_evt = tb_en && (load_sel ? at_prd : at_zero);

  pwm_period_reg #(.CW(CW)) u_prd (
    .clk(clk), .rst(rst), .wr_prd(wr_prd), .wr_data(wr_data),
    .load_mode(load_mode), .load_evt(load_evt), .prd_act(prd_act)
  );

  pwm_tb_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(tb_en), .prd(prd_act), .cnt(cnt),
    .up_eff(up_eff), .at_zero(at_zero), .at_prd(at_prd)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic hit;
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_r[g] <= '0;
          act_r[g] <= act_cfg_t'('0);
        end else if (wr_en) begin
          if (wr_addr == AW'(ADDR_CMP_A + g)) cmp_r[g] <= wr_data;
          if (wr_addr == AW'(ADDR_ACT_A + g)) act_r[g] <= act_cfg_t'(wr_data[ABITS-1:0]);
        end
      end
      assign hit = tb_en && (cnt == cmp_r[g]);
      pwm_action_out u_act (
        .clk(clk), .rst(rst),
        .ev_zro(tb_en && at_zero), .ev_prd(tb_en && at_prd),
        .ev_cup(hit && up_eff), .ev_cdn(hit && !up_eff),
        .cfg(act_r[g]), .pwm_o(pwm[g])
      );
    end
  endgenerate

  assign out_a = pwm[0];
  assign out_b = pwm[1];

  // R1: after reset the outputs are low
  p_reset_r1: assert property (@(posedge clk) rst |=> !out_a && !out_b);
endmodule

// File: tb/sim_updown_pwm_core.sv
module sim_updown_pwm_core;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  a;
    logic  b;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, tb_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic load_mode = 1'b0, load_sel = 1'b0;
  logic out_a, out_b;

  int n_tests = 0, n_fail = 0;
  bit mon_on = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_pwm_core u0 (
    .clk(clk), .rst(rst), .tb_en(tb_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_mode(load_mode), .load_sel(load_sel),
    .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got a,b=%b expected %b", tag, act, exp);
    end
  endtask

  // monitor: one expected item per clock after the edge
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({out_a, out_b} == {e.a, e.b}, e.tag, {out_a, out_b}, {e.a, e.b});
    end
  end

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; tb_en = 1'b0; load_mode = mode; load_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic a, input logic b, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run_queue();
    @(negedge clk);
    tb_en = 1'b1;
    @(posedge clk);
    #1 mon_on = 1'b1;
    wait (q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0; tb_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // ---- R1 reset state, R2 hold while disabled, R4 address map ----
    do_reset(1'b0);
    #1 chk({out_a, out_b} == 2'b00, "R1 reset outputs", {out_a, out_b}, 2'b00);
    wr(3'd0, 16'd300);          // period, direct (R6)
    wr(3'd1, 16'd100);          // compare A
    wr(3'd3, 16'h0012);         // A: zero high, cmp-up low
    wr(3'd4, 16'h0009);         // B: period high, zero low
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk({out_a, out_b} == 2'b00, "R2 hold while tb_en low", {out_a, out_b}, 2'b00);
    end
    // ---- direct mode, P=300: R3 R4 R5 R6 ----
    for (int k = 0; k < 1200; k++) begin
      int m;
      m = k % 600;
      push(m < 100, m >= 300, "R3/R5/R6 direct P=300");
    end
    run_queue();

    // ---- shadow mode start with empty active period: R7 R9 R11 ----
    for (int s = 0; s < 2; s++) begin
      do_reset(1'b1);
      load_sel = s[0];
      wr(3'd0, 16'd300);
      wr(3'd1, 16'd100);
      wr(3'd3, 16'h0012);
      wr(3'd4, 16'h0009);
      push(1'b1, 1'b1, "R9/R11 zero+period coincide at start");
      for (int k = 1; k < 1201; k++) begin
        int m;
        m = (k - 1) % 600;
        push(m < 100, m >= 300, "R7 shadow load then P=300");
      end
      run_queue();
    end

    // ---- mode rise copies empty shadow: R8 ----
    do_reset(1'b0);
    wr(3'd3, 16'h0012);
    wr(3'd4, 16'h0009);
    wr(3'd0, 16'd300);
    @(negedge clk);
    load_mode = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 20; k++) push(1'b1, 1'b1, "R8 mode switch loads shadow 0");
    run_queue();

    // ---- compare up/down and toggle: R10 R5 ----
    do_reset(1'b0);
    wr(3'd0, 16'd100);
    wr(3'd1, 16'd50);
    wr(3'd2, 16'd50);
    wr(3'd3, 16'h0060);         // A: cmp-up high, cmp-down low
    wr(3'd4, 16'h00C0);         // B: cmp-down toggle
    for (int k = 0; k < 400; k++) begin
      int m, t;
      m = k % 200;
      t = (k < 150) ? 0 : ((k - 150) / 200 + 1);
      push((m >= 50) && (m < 150), t[0], "R10/R5 compare up/down toggle");
    end
    run_queue();

    // ---- compare coinciding with peak and bottom: R9 R10 ----
    do_reset(1'b0);
    wr(3'd0, 16'd100);
    wr(3'd1, 16'd100);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h0084);         // A: cmp-down high, period low
    wr(3'd4, 16'h0021);         // B: cmp-up high, zero low
    for (int k = 0; k < 400; k++) push(1'b0, 1'b0, "R9 period/zero outrank compare");
    run_queue();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule